// File: doc/BRIEF.md
# Thread segment bound and swap unit

When a thread enters a protected execution region, its FS and GS segments must be replaced by thread-local segments. This unit works out where those segments lie. Each proposed base is a control-structure offset added to the region's base address. In 32-bit mode the unit also checks that each proposed segment fits inside the current DS segment. In 64-bit mode it checks only that each base is a canonical address.

If every check passes on a commit strobe, the unit does two things in the same clock cycle. It keeps a copy of the caller's current FS and GS descriptors, and it presents replacement descriptors. Some attribute bits of the replacements are fixed; the others are copied from DS. A later restore command puts the kept copies back on the outputs and ends the swap. If a check fails, the commit raises a fault flag and changes nothing else.

Top module: `tseg_swap_unit`

## Requirements
- R1: After reset, every descriptor output, both saved copies, `fault_o` and `entered_o` are all zero.
- R2: A commit faults when either the FS or the GS offset has a nonzero value in its low 12 bits (not 4 KiB aligned). This applies in both modes.
- R3: In 32-bit mode (`mode64_i`=0), a base is the low 32 bits of offset + region base, zero-extended to 64 bits. The segment's end address is that base + its segment limit.
- R4: In 32-bit mode, when the end address produces no carry out of bit 31, the commit faults exactly when the end address is greater than `ds_limit_i`. An end address equal to `ds_limit_i` is accepted.
- R5: In 32-bit mode, when the end address addition carries out of bit 31 (wrap-around), the commit faults unless `ds_limit_i` is 32'hFFFF_FFFF.
- R6: In 64-bit mode, a base is the full 64-bit sum of offset and region base. The commit faults if bits 63..47 of a base are not all equal (non-canonical). No comparison with `ds_limit_i` is made in this mode.
- R7: On a commit that does not fault, `fs_save_o` and `gs_save_o` capture `cur_fs_i` and `cur_gs_i`.
- R8: On a commit that does not fault, each loaded descriptor gets the computed base and the control-structure limit. Its fixed fields are selector 16'h000B, type 4'b0001, S=1, G=1, B=1, P=1 and unusable=0. Its W, DPL, AVL and L fields are copied from the DS inputs. `entered_o` goes to 1.
- R9: Every commit writes `fault_o`: 1 if the commit faulted, 0 if it did not. A faulting commit changes no descriptor, no saved copy and no `entered_o`. Without a commit, `fault_o` keeps its value.
- R10: A commit made while `entered_o`=1 faults.
- R11: A restore made while `entered_o`=1, with no commit in the same cycle, loads `fs_o`/`gs_o` from the saved copies and clears `entered_o`. A restore made while `entered_o`=0 has no effect.
- R12: Each descriptor is a packed 126-bit vector. From the MSB down, its fields are selector[15:0], base[63:0], limit[31:0], type[3:0], W, S, DPL[1:0], P, AVL, L, B, G, unusable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | One-cycle strobe that checks the inputs and swaps if they pass |
| restore_i | input | 1 | One-cycle strobe that returns the saved descriptors |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| encl_base_i | input | 64 | Base address of the protected region |
| fs_off_i | input | 64 | Proposed FS offset from the control structure |
| gs_off_i | input | 64 | Proposed GS offset from the control structure |
| fs_lim_i | input | 32 | Proposed FS segment limit |
| gs_lim_i | input | 32 | Proposed GS segment limit |
| ds_limit_i | input | 32 | Current DS limit (highest legal address) |
| ds_wr_i | input | 1 | DS writable bit |
| ds_dpl_i | input | 2 | DS privilege level |
| ds_avl_i | input | 1 | DS available bit |
| ds_l_i | input | 1 | DS long bit |
| cur_fs_i | input | 126 | Caller's current FS descriptor |
| cur_gs_i | input | 126 | Caller's current GS descriptor |
| fs_o | output | 126 | FS descriptor now in effect |
| gs_o | output | 126 | GS descriptor now in effect |
| fs_save_o | output | 126 | Saved copy of the caller's FS descriptor |
| gs_save_o | output | 126 | Saved copy of the caller's GS descriptor |
| fault_o | output | 1 | Result of the last commit (1 = faulted) |
| entered_o | output | 1 | Swap in effect |

## Verification
The bench exercises an end address exactly equal to the DS limit and one address past it. An off-by-one comparison would reject the first case or accept the second. It also drives a segment that wraps past 4 GiB, once with a full DS limit and once with a limit one short. A design that ignored the carry would take the wrapped end address as a small value and pass it against the smaller limit. In 64-bit mode, a DS limit of zero is paired with a valid commit and with a base whose bit 47 is set. A design that still compared against DS, or tested the wrong canonical bits, would get one of these wrong. A second commit while the swap is in effect, a restore with no swap in effect, and a misaligned offset must all leave the descriptor and saved-copy outputs unchanged. A design that leaked a partial update would show altered outputs.

// File: rtl/tseg_pkg.sv
package tseg_pkg;

    localparam int ADDR_W = 64;
    localparam int LIM_W  = 32;
    localparam int SEL_W  = 16;
    localparam int NSEG   = 2;

    // Hidden descriptor image, MSB first
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [3:0]        typ;
        logic              wr;
        logic              s;
        logic [1:0]        dpl;
        logic              p;
        logic              avl;
        logic              l;
        logic              db;
        logic              g;
        logic              unusable;
    } seg_desc_t;

    localparam int DESC_W = $bits(seg_desc_t);

    // Attribute bits taken from the data segment
    typedef struct packed {
        logic       wr;
        logic [1:0] dpl;
        logic       avl;
        logic       l;
    } ds_attr_t;

endpackage

// File: rtl/tseg_bound_chk.sv
module tseg_bound_chk
    import tseg_pkg::*;
#(
    parameter int VA_BITS   = 48,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode64_i,
    input  logic [ADDR_W-1:0] encl_base_i,
    input  logic [ADDR_W-1:0] off_i,
    input  logic [LIM_W-1:0]  seg_lim_i,
    input  logic [LIM_W-1:0]  ds_limit_i,
    output logic [ADDR_W-1:0] base_o,
    output logic              fault_o
);

    localparam int HI_W    = ADDR_W - LIM_W;
    localparam int CANON_W = ADDR_W - VA_BITS + 1;

    logic [ADDR_W-1:0]  sum_full;
    logic [LIM_W-1:0]   base_narrow;
    logic [LIM_W:0]     end_wide;
    logic               misaligned;
    logic               wrapped;
    logic               ds_full;
    logic               narrow_bad;
    logic [CANON_W-1:0] canon_top;
    logic               canon_bad;

    always_comb begin
        misaligned  = |off_i[PAGE_BITS-1:0];
        sum_full    = off_i + encl_base_i;
        base_narrow = sum_full[LIM_W-1:0];
        // 33-bit add; the carry marks wrap-around
        end_wide    = {1'b0, base_narrow} + {1'b0, seg_lim_i};
        wrapped     = end_wide[LIM_W];
        ds_full     = &ds_limit_i;
        if (wrapped) begin
            narrow_bad = !ds_full;
        end else begin
            narrow_bad = end_wide[LIM_W-1:0] > ds_limit_i;
        end
        canon_top = sum_full[ADDR_W-1:VA_BITS-1];
        canon_bad = !((&canon_top) || (~|canon_top));
        if (mode64_i) begin
            base_o  = sum_full;
            fault_o = misaligned || canon_bad;
        end else begin
            base_o  = {{HI_W{1'b0}}, base_narrow};
            fault_o = misaligned || narrow_bad;
        end
    end

    // Any misaligned offset must fault
    p_misalign_faults_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (off_i[PAGE_BITS-1:0] != '0) |-> fault_o);

    // 32-bit bases never carry upper bits
    p_narrow_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode64_i |-> (base_o[ADDR_W-1:LIM_W] == '0));

    // A full 4 GiB DS accepts any aligned 32-bit segment
    p_full_ds_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode64_i && (off_i[PAGE_BITS-1:0] == '0) && (ds_limit_i == '1)) |-> !fault_o);

    // 64-bit check ignores DS limit: an aligned upper-zero base passes
    p_wide_no_ds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode64_i && (off_i[PAGE_BITS-1:0] == '0) && (base_o[ADDR_W-1:VA_BITS-1] == '0)) |-> !fault_o);

endmodule

// File: rtl/tseg_desc_build.sv
module tseg_desc_build
    import tseg_pkg::*;
#(
    parameter logic [SEL_W-1:0] NEW_SEL  = 16'h000B,
    parameter logic [3:0]       NEW_TYPE = 4'b0001
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LIM_W-1:0]  limit_i,
    input  ds_attr_t          ds_i,
    output seg_desc_t         desc_o
);

    always_comb begin
        desc_o          = '0;
        desc_o.sel      = NEW_SEL;
        desc_o.base     = base_i;
        desc_o.limit    = limit_i;
        desc_o.typ      = NEW_TYPE;
        desc_o.wr       = ds_i.wr;
        desc_o.s        = 1'b1;
        desc_o.dpl      = ds_i.dpl;
        desc_o.p        = 1'b1;
        desc_o.avl      = ds_i.avl;
        desc_o.l        = ds_i.l;
        desc_o.db       = 1'b1;
        desc_o.g        = 1'b1;
        desc_o.unusable = 1'b0;
    end

endmodule

// File: rtl/tseg_swap_unit.sv
module tseg_swap_unit
    import tseg_pkg::*;
#(
    parameter int               VA_BITS   = 48,
    parameter int               PAGE_BITS = 12,
    parameter logic [SEL_W-1:0] NEW_SEL   = 16'h000B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              restore_i,
    input  logic              mode64_i,
    input  logic [ADDR_W-1:0] encl_base_i,
    input  logic [ADDR_W-1:0] fs_off_i,
    input  logic [ADDR_W-1:0] gs_off_i,
    input  logic [LIM_W-1:0]  fs_lim_i,
    input  logic [LIM_W-1:0]  gs_lim_i,
    input  logic [LIM_W-1:0]  ds_limit_i,
    input  logic              ds_wr_i,
    input  logic [1:0]        ds_dpl_i,
    input  logic              ds_avl_i,
    input  logic              ds_l_i,
    input  logic [DESC_W-1:0] cur_fs_i,
    input  logic [DESC_W-1:0] cur_gs_i,
    output logic [DESC_W-1:0] fs_o,
    output logic [DESC_W-1:0] gs_o,
    output logic [DESC_W-1:0] fs_save_o,
    output logic [DESC_W-1:0] gs_save_o,
    output logic              fault_o,
    output logic              entered_o
);

    localparam int FS_IDX = 0;
    localparam int GS_IDX = 1;

    typedef struct packed {
        seg_desc_t fs;
        seg_desc_t gs;
        seg_desc_t fs_sv;
        seg_desc_t gs_sv;
        logic      fault;
        logic      entered;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [ADDR_W-1:0] off_a   [NSEG];
    logic [LIM_W-1:0]  lim_a   [NSEG];
    logic [ADDR_W-1:0] base_a  [NSEG];
    logic [NSEG-1:0]   seg_flt;
    seg_desc_t         new_a   [NSEG];
    ds_attr_t          ds_attr;
    logic              fault_now;

    always_comb begin
        off_a[FS_IDX] = fs_off_i;
        off_a[GS_IDX] = gs_off_i;
        lim_a[FS_IDX] = fs_lim_i;
        lim_a[GS_IDX] = gs_lim_i;
        ds_attr.wr    = ds_wr_i;
        ds_attr.dpl   = ds_dpl_i;
        ds_attr.avl   = ds_avl_i;
        ds_attr.l     = ds_l_i;
    end

    for (genvar gi = 0; gi < NSEG; gi++) begin : g_seg
        tseg_bound_chk #(
            .VA_BITS   (VA_BITS),
            .PAGE_BITS (PAGE_BITS)
        ) u_chk (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode64_i    (mode64_i),
            .encl_base_i (encl_base_i),
            .off_i       (off_a[gi]),
            .seg_lim_i   (lim_a[gi]),
            .ds_limit_i  (ds_limit_i),
            .base_o      (base_a[gi]),
            .fault_o     (seg_flt[gi])
        );

        tseg_desc_build #(
            .NEW_SEL (NEW_SEL)
        ) u_build (
            .base_i  (base_a[gi]),
            .limit_i (lim_a[gi]),
            .ds_i    (ds_attr),
            .desc_o  (new_a[gi])
        );
    end

    assign fault_now = st_q.entered || (|seg_flt);

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            if (fault_now) begin
                st_d.fault = 1'b1;
            end else begin
                st_d.fault   = 1'b0;
                st_d.fs_sv   = seg_desc_t'(cur_fs_i);
                st_d.gs_sv   = seg_desc_t'(cur_gs_i);
                st_d.fs      = new_a[FS_IDX];
                st_d.gs      = new_a[GS_IDX];
                st_d.entered = 1'b1;
            end
        end else if (restore_i && st_q.entered) begin
            st_d.fs      = st_q.fs_sv;
            st_d.gs      = st_q.gs_sv;
            st_d.entered = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fs_o      = st_q.fs;
    assign gs_o      = st_q.gs;
    assign fs_save_o = st_q.fs_sv;
    assign gs_save_o = st_q.gs_sv;
    assign fault_o   = st_q.fault;
    assign entered_o = st_q.entered;

    // Successful commit captures the caller's descriptors
    p_save_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !fault_now) |=>
            (fs_save_o == $past(cur_fs_i)) && (gs_save_o == $past(cur_gs_i)) && entered_o);

    // While swapped, the loaded descriptors carry the fixed attributes
    p_fixed_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entered_o |->
            (st_q.fs.sel == NEW_SEL) && (st_q.gs.sel == NEW_SEL) &&
            (st_q.fs.typ == 4'b0001) && (st_q.gs.typ == 4'b0001) &&
            st_q.fs.s && st_q.fs.g && st_q.fs.db && st_q.fs.p && !st_q.fs.unusable &&
            st_q.gs.s && st_q.gs.g && st_q.gs.db && st_q.gs.p && !st_q.gs.unusable);

    // A faulting commit touches nothing but the flag
    p_fault_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && fault_now) |=>
            fault_o && $stable(fs_o) && $stable(gs_o) &&
            $stable(fs_save_o) && $stable(gs_save_o) && $stable(entered_o));

    // Without any command the whole state is held
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !restore_i) |=>
            $stable(fs_o) && $stable(gs_o) && $stable(fault_o) && $stable(entered_o));

    // Entering twice is refused
    p_reenter_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && entered_o) |=> fault_o);

    // Restore returns the saved pair and ends the swap
    p_restore_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !commit_i && entered_o) |=>
            !entered_o && (fs_o == $past(fs_save_o)) && (gs_o == $past(gs_save_o)));

endmodule

// File: tb/tseg_swap_unit_tb.sv
module tseg_swap_unit_tb;
    import tseg_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              commit_i, restore_i, mode64_i;
    logic [ADDR_W-1:0] encl_base_i, fs_off_i, gs_off_i;
    logic [LIM_W-1:0]  fs_lim_i, gs_lim_i, ds_limit_i;
    logic              ds_wr_i, ds_avl_i, ds_l_i;
    logic [1:0]        ds_dpl_i;
    logic [DESC_W-1:0] cur_fs_i, cur_gs_i;
    logic [DESC_W-1:0] fs_o, gs_o, fs_save_o, gs_save_o;
    logic              fault_o, entered_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tseg_swap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .restore_i(restore_i),
        .mode64_i(mode64_i), .encl_base_i(encl_base_i),
        .fs_off_i(fs_off_i), .gs_off_i(gs_off_i),
        .fs_lim_i(fs_lim_i), .gs_lim_i(gs_lim_i), .ds_limit_i(ds_limit_i),
        .ds_wr_i(ds_wr_i), .ds_dpl_i(ds_dpl_i), .ds_avl_i(ds_avl_i), .ds_l_i(ds_l_i),
        .cur_fs_i(cur_fs_i), .cur_gs_i(cur_gs_i),
        .fs_o(fs_o), .gs_o(gs_o), .fs_save_o(fs_save_o), .gs_save_o(gs_save_o),
        .fault_o(fault_o), .entered_o(entered_o)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic seg_desc_t exp_new(input logic [63:0] b, input logic [31:0] lim);
        seg_desc_t d;
        d = '0;
        d.sel = 16'h000B; d.base = b; d.limit = lim; d.typ = 4'b0001;
        d.wr = ds_wr_i; d.s = 1'b1; d.dpl = ds_dpl_i; d.p = 1'b1;
        d.avl = ds_avl_i; d.l = ds_l_i; d.db = 1'b1; d.g = 1'b1; d.unusable = 1'b0;
        return d;
    endfunction

    function automatic seg_desc_t mk_cur(input logic [15:0] sel, input logic [63:0] b,
                                         input logic [31:0] lim, input logic [3:0] t);
        seg_desc_t d;
        d = '0;
        d.sel = sel; d.base = b; d.limit = lim; d.typ = t;
        d.wr = 1'b1; d.s = 1'b1; d.p = 1'b1; d.g = 1'b0; d.db = 1'b1;
        return d;
    endfunction

    task automatic pulse_commit();
        @(negedge clk); commit_i = 1'b1;
        @(negedge clk); commit_i = 1'b0;
    endtask

    task automatic pulse_restore();
        @(negedge clk); restore_i = 1'b1;
        @(negedge clk); restore_i = 1'b0;
    endtask

    task automatic set32(input logic [63:0] eb, input logic [63:0] fo, input logic [63:0] go,
                         input logic [31:0] fl, input logic [31:0] gl, input logic [31:0] dl);
        mode64_i = 1'b0; encl_base_i = eb; fs_off_i = fo; gs_off_i = go;
        fs_lim_i = fl; gs_lim_i = gl; ds_limit_i = dl;
    endtask

    task automatic t_reset();
        chk("R1 fs", fs_o, '0);
        chk("R1 gs", gs_o, '0);
        chk("R1 saves", {fs_save_o, gs_save_o} == '0, 1);
        chk("R1 flags", {fault_o, entered_o}, 0);
    endtask

    task automatic t_enter32();
        set32(64'h1000_0000, 64'h2000, 64'h5000, 32'h0FFF, 32'h1FFF, 32'hFFFF_FFFF);
        pulse_commit();
        chk("R9 fault clear", fault_o, 0);
        chk("R8 entered", entered_o, 1);
        chk("R3 R8 R12 fs", fs_o, exp_new(64'h1000_2000, 32'h0FFF));
        chk("R3 R8 R12 gs", gs_o, exp_new(64'h1000_5000, 32'h1FFF));
        chk("R7 fs save", fs_save_o, cur_fs_i);
        chk("R7 gs save", gs_save_o, cur_gs_i);
    endtask

    task automatic t_restore();
        logic [DESC_W-1:0] sfs, sgs;
        sfs = fs_save_o; sgs = gs_save_o;
        pulse_restore();
        chk("R11 fs back", fs_o, sfs);
        chk("R11 gs back", gs_o, sgs);
        chk("R11 entered clr", entered_o, 0);
    endtask

    task automatic t_restore_idle();
        logic [DESC_W-1:0] pfs, pgs;
        pfs = fs_o; pgs = gs_o;
        pulse_restore();
        chk("R11 idle fs", fs_o, pfs);
        chk("R11 idle gs", gs_o, pgs);
        chk("R11 idle entered", entered_o, 0);
    endtask

    task automatic t_fault_expect(input string tag);
        logic [DESC_W-1:0] pfs, pgs, psf, psg;
        logic pen;
        pfs = fs_o; pgs = gs_o; psf = fs_save_o; psg = gs_save_o; pen = entered_o;
        pulse_commit();
        chk({tag, " fault"}, fault_o, 1);
        chk({tag, " R9 fs kept"}, fs_o, pfs);
        chk({tag, " R9 gs kept"}, gs_o, pgs);
        chk({tag, " R9 saves kept"}, {fs_save_o, gs_save_o} == {psf, psg}, 1);
        chk({tag, " R9 entered kept"}, entered_o, pen);
    endtask

    task automatic t_misalign();
        set32(64'h1000_0000, 64'h2000, 64'h5800, 32'h0FFF, 32'h0FFF, 32'hFFFF_FFFF);
        t_fault_expect("R2");
    endtask

    task automatic t_edge32();
        cur_fs_i = mk_cur(16'h0043, 64'h0000_9000, 32'h0000_0400, 4'b0011);
        set32(64'h2000_0000, 64'h1000, 64'h3000, 32'h0FFF, 32'h0FFF, 32'h2000_3FFF);
        pulse_commit();
        chk("R4 equal ok", fault_o, 0);
        chk("R4 gs base", gs_o, exp_new(64'h2000_3000, 32'h0FFF));
        chk("R7 new fs save", fs_save_o, cur_fs_i);
        t_restore();
        ds_limit_i = 32'h2000_3FFE;
        t_fault_expect("R4 one past");
    endtask

    task automatic t_wrap32();
        set32(64'hFFFF_E000, 64'h1000, 64'h0, 32'h1FFF, 32'h0FFF, 32'hFFFF_FFFF);
        pulse_commit();
        chk("R5 wrap full ok", fault_o, 0);
        chk("R5 R3 fs base", fs_o, exp_new(64'h0000_0000_FFFF_F000, 32'h1FFF));
        t_restore();
        ds_limit_i = 32'hFFFF_FFFE;
        t_fault_expect("R5 wrap short");
    endtask

    task automatic t_wide();
        mode64_i = 1'b1; encl_base_i = 64'h0000_7FFF_0000_0000;
        fs_off_i = 64'h0010_0000; gs_off_i = 64'h2000;
        fs_lim_i = 32'h5; gs_lim_i = 32'hFFFF_FFFF; ds_limit_i = 32'h0;
        pulse_commit();
        chk("R6 no ds compare", fault_o, 0);
        chk("R6 fs base", fs_o, exp_new(64'h0000_7FFF_0010_0000, 32'h5));
        chk("R6 gs base", gs_o, exp_new(64'h0000_7FFF_0000_2000, 32'hFFFF_FFFF));
        t_fault_expect("R10 reenter");
        t_restore();
        t_restore_idle();
        encl_base_i = 64'h0000_7FFF_FFFF_F000; fs_off_i = 64'h1000;
        t_fault_expect("R6 noncanon");
        encl_base_i = 64'hFFFF_8000_0000_0000; fs_off_i = 64'h0; gs_off_i = 64'h0;
        pulse_commit();
        chk("R6 upper canonical ok", fault_o, 0);
        chk("R6 upper base", fs_o, exp_new(64'hFFFF_8000_0000_0000, 32'h5));
        t_restore();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; commit_i = 1'b0; restore_i = 1'b0; mode64_i = 1'b0;
        encl_base_i = '0; fs_off_i = '0; gs_off_i = '0;
        fs_lim_i = '0; gs_lim_i = '0; ds_limit_i = '0;
        ds_wr_i = 1'b1; ds_dpl_i = 2'b11; ds_avl_i = 1'b1; ds_l_i = 1'b0;
        cur_fs_i = mk_cur(16'h0033, 64'h0000_ABC0, 32'h77, 4'b0011);
        cur_gs_i = mk_cur(16'h003B, 64'h0001_2340, 32'h99, 4'b0010);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enter32();
        t_restore();
        chk("R9 fault held", fault_o, 0);
        t_misalign();
        t_edge32();
        t_wrap32();
        t_wide();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule